// File: doc/BRIEF.md
# SD Native-Mode Command Line Transceiver

This block owns the single command wire of an SD card running in its native (non-SPI) protocol, together with the card clock. A host pulses a start strobe with a 6-bit command index, a 32-bit argument and the kind of reply it expects. The block then gives the card twelve idle clocks with the wire released and shifts out a 48-bit command token, most significant bit first, with a CRC7 computed on the fly. After that it releases the wire again and keeps clocking the card until a zero start bit shows up. It then captures a 48-bit or 136-bit reply and reports whether the reply timed out or failed its CRC7.

Outgoing bits change on falling card-clock edges and incoming bits are sampled on rising edges. The card clock runs only while a transaction is in progress and is parked low otherwise. The captured reply stays on the output, right-aligned, until the next command starts. Replies to operating-condition queries carry no valid CRC, so the check is skipped for that reply kind.

Top module: `sd_cmd_xcvr`

## Requirements
- R1: The transmitted token is 48 bits, sent MSB first on `cmdOut` with `cmdOe` high: bit 47 = 0, bit 46 = 1, bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC7, bit 0 = 1.
- R2: The CRC7 is the remainder of the 40 leading token bits times x^7 divided by x^7 + x^3 + 1; index 0 with argument 0 gives a last byte of 0x95.
- R3: `cmdOut` changes only at the system edge where the card clock falls; reply bits are sampled at rising card-clock edges.
- R4: Exactly 12 rising card-clock edges occur with `cmdOe` low between the start strobe and the first token bit; `cmdOe` is high for the 48 token bits only.
- R5: `respKind` encodes 0 = no reply, 1 = 48-bit reply with CRC, 2 = 48-bit reply without CRC, 3 = 136-bit reply; kind 0 finishes right after the token with no timeout.
- R6: After the token the card clock keeps running, and a zero sampled on any of the first 64 rising edges is taken as the reply start bit.
- R7: If 64 rising edges pass with the wire high, `respTimeout` is set, `respCrcErr` stays clear and `respWord` stays zero.
- R8: `respWord` holds the reply right-aligned with the start bit included: a 48-bit reply in bits 47:0 with bits 135:48 zero, a 136-bit reply in bits 135:0.
- R9: For kind 1 the CRC7 over reply bits 47:8 is compared with bits 7:1, and `respCrcErr` is set on a mismatch.
- R10: For kind 3 the CRC7 over reply bits 127:8 only is compared with bits 7:1, and `respCrcErr` is set on a mismatch.
- R11: For kind 2 `respCrcErr` is never set, whatever the CRC field holds.
- R12: A start strobe while `busy` is high is ignored: the token in flight is unchanged and exactly one `done` pulse follows.
- R13: When idle, `busy` is low and `cardClk` is low; `done` is a one-cycle pulse that comes with `busy` falling and the card clock parked low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle strobe that starts a command when idle |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| respKind | input | 2 | Expected reply kind (0 none, 1 short with CRC, 2 short without CRC, 3 long) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| respTimeout | output | 1 | No start bit within the reply window |
| respCrcErr | output | 1 | Reply CRC7 mismatch |
| respWord | output | 136 | Captured reply, right-aligned |
| cardClk | output | 1 | Gated card clock |
| cmdOut | output | 1 | Value driven on the command wire |
| cmdOe | output | 1 | Drive enable for the command wire (released means pulled high) |
| cmdIn | input | 1 | Sampled level of the command wire |

## Verification
The start-bit search and the timeout count act on the same rising card-clock edge. When the card's first zero lands on the 64th edge after the token, one edge decides between a captured reply and a timeout. The bench sets the card latency to exactly 64 and to 65 and checks the outcome. At 64 it expects the full reply with `respTimeout` clear, and at 65 it expects `respTimeout` set with an empty `respWord`. Random latencies across the whole window, with randomly corrupted CRC fields on all three reply kinds, cover the rest of the capture and check paths.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int TOKEN_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int MSG_BITS   = 40;
  localparam int CRC_W      = 7;
  localparam int CRC_LOW    = 8;
  localparam logic [CRC_W-1:0] CRC7_POLY = 7'h09;

  typedef enum logic [1:0] {
    RESP_NONE        = 2'd0,
    RESP_SHORT       = 2'd1,
    RESP_SHORT_NOCRC = 2'd2,
    RESP_LONG        = 2'd3
  } respKind_e;

  typedef enum logic [1:0] {
    TX_MSG = 2'd0,
    TX_CRC = 2'd1,
    TX_END = 2'd2
  } txSel_e;

  typedef struct packed {
    logic   loadTx;
    logic   txShift;
    txSel_e txSel;
    logic   rxClear;
    logic   rxShift;
    logic   rxCrcEn;
    logic   rxCheck;
    logic   checkCrc;
  } dpStrobe_t;

  // one serial step of the x^7 + x^3 + 1 remainder register
  function automatic logic [CRC_W-1:0] crc7Step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC7_POLY : '0);
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clkEn,
  output logic cardClk,
  output logic riseEv,
  output logic fallEv
);
  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             clkQ;
  logic             tick;

  assign tick    = clkEn && (divCnt == DIV_W'(CLK_HALF - 1));
  assign riseEv  = tick && !clkQ;
  assign fallEv  = tick && clkQ;
  assign cardClk = clkQ;

  always_ff @(posedge clk) begin
    if (!rstN || !clkEn) begin
      divCnt <= '0;
      clkQ   <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      clkQ   <= ~clkQ;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // R13: the card clock only rises while gating is enabled
  a_r13_clk_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardClk) |-> $past(clkEn));

endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int IDLE_CLKS    = 12,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [1:0] respKind,
  input  logic       cmdIn,
  input  logic       riseEv,
  input  logic       fallEv,
  output dpStrobe_t  stb,
  output logic       clkEn,
  output logic       cmdOe,
  output logic       busy,
  output logic       done,
  output logic       respTimeout
);
  localparam int CNT_TOP0 = (RESP_TIMEOUT > LONG_BITS) ? RESP_TIMEOUT : LONG_BITS;
  localparam int CNT_TOP  = (IDLE_CLKS > CNT_TOP0) ? IDLE_CLKS : CNT_TOP0;
  localparam int CNT_W    = $clog2(CNT_TOP + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SEND, ST_WAIT, ST_RECV, ST_STOP
  } ctrlState_e;

  ctrlState_e       state;
  respKind_e        kindQ;
  logic [CNT_W-1:0] bitCnt;
  logic             cmdOeQ, doneQ, timeoutQ;
  logic [CNT_W-1:0] rxTotal, rxHi, rxPos;
  logic             inWin;

  assign rxTotal = (kindQ == RESP_LONG) ? CNT_W'(LONG_BITS) : CNT_W'(TOKEN_BITS);
  assign rxHi    = (kindQ == RESP_LONG) ? CNT_W'(LONG_BITS - 9) : CNT_W'(TOKEN_BITS - 1);
  assign rxPos   = rxTotal - CNT_W'(1) - bitCnt;
  assign inWin   = (rxPos >= CNT_W'(CRC_LOW)) && (rxPos <= rxHi);

  assign clkEn       = (state != ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign cmdOe       = cmdOeQ;
  assign done        = doneQ;
  assign respTimeout = timeoutQ;

  always_comb begin
    stb       = '0;
    stb.txSel = TX_MSG;
    unique case (state)
      ST_IDLE: if (cmdStart) begin
        stb.loadTx  = 1'b1;
        stb.rxClear = 1'b1;
      end
      ST_PRE: if (fallEv && bitCnt == CNT_W'(IDLE_CLKS)) stb.txShift = 1'b1;
      ST_SEND: if (fallEv && bitCnt < CNT_W'(TOKEN_BITS)) begin
        stb.txShift = 1'b1;
        if (bitCnt < CNT_W'(MSG_BITS))           stb.txSel = TX_MSG;
        else if (bitCnt < CNT_W'(TOKEN_BITS - 1)) stb.txSel = TX_CRC;
        else                                      stb.txSel = TX_END;
      end
      ST_WAIT: if (riseEv && !cmdIn) begin
        stb.rxShift = 1'b1;
        stb.rxCrcEn = inWin;
      end
      ST_RECV: if (riseEv) begin
        stb.rxShift = 1'b1;
        stb.rxCrcEn = inWin;
      end
      ST_STOP: if (fallEv) begin
        stb.rxCheck  = 1'b1;
        stb.checkCrc = !timeoutQ && (kindQ == RESP_SHORT || kindQ == RESP_LONG);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kindQ    <= RESP_NONE;
      bitCnt   <= '0;
      cmdOeQ   <= 1'b0;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmdStart) begin
          kindQ    <= respKind_e'(respKind);
          timeoutQ <= 1'b0;
          bitCnt   <= '0;
          state    <= ST_PRE;
        end
        ST_PRE: begin
          if (riseEv) bitCnt <= bitCnt + CNT_W'(1);
          if (fallEv && bitCnt == CNT_W'(IDLE_CLKS)) begin
            cmdOeQ <= 1'b1;
            bitCnt <= CNT_W'(1);
            state  <= ST_SEND;
          end
        end
        ST_SEND: if (fallEv) begin
          if (bitCnt == CNT_W'(TOKEN_BITS)) begin
            cmdOeQ <= 1'b0;
            bitCnt <= '0;
            if (kindQ == RESP_NONE) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_WAIT: if (riseEv) begin
          if (!cmdIn) begin
            bitCnt <= CNT_W'(1);
            state  <= ST_RECV;
          end else if (bitCnt == CNT_W'(RESP_TIMEOUT - 1)) begin
            timeoutQ <= 1'b1;
            state    <= ST_STOP;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_RECV: if (riseEv) begin
          if (bitCnt == rxTotal - CNT_W'(1)) state <= ST_STOP;
          else                               bitCnt <= bitCnt + CNT_W'(1);
        end
        ST_STOP: if (fallEv) begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the drive enable only turns on at a falling card-clock edge
  a_r4_oe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> $past(fallEv));

  // R13: completion is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [5:0]           cmdIndex,
  input  logic [31:0]          cmdArg,
  input  logic                 cmdIn,
  output logic                 cmdOut,
  output logic [LONG_BITS-1:0] respWord,
  output logic                 respCrcErr
);
  logic [MSG_BITS-1:0]  msgQ;
  logic [CRC_W-1:0]     txCrcQ, rxCrcQ;
  logic                 cmdOutQ, crcErrQ;
  logic [LONG_BITS-1:0] rxWordQ;
  logic                 txShiftEv;

  assign cmdOut     = cmdOutQ;
  assign respWord   = rxWordQ;
  assign respCrcErr = crcErrQ;
  assign txShiftEv  = stb.txShift;

  // transmit side: message bits feed the CRC as they leave
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgQ    <= '0;
      txCrcQ  <= '0;
      cmdOutQ <= 1'b1;
    end else if (stb.loadTx) begin
      msgQ   <= {2'b01, cmdIndex, cmdArg};
      txCrcQ <= '0;
    end else if (stb.txShift) begin
      unique case (stb.txSel)
        TX_MSG: begin
          cmdOutQ <= msgQ[MSG_BITS-1];
          msgQ    <= {msgQ[MSG_BITS-2:0], 1'b0};
          txCrcQ  <= crc7Step(txCrcQ, msgQ[MSG_BITS-1]);
        end
        TX_CRC: begin
          cmdOutQ <= txCrcQ[CRC_W-1];
          txCrcQ  <= {txCrcQ[CRC_W-2:0], 1'b0};
        end
        default: cmdOutQ <= 1'b1;
      endcase
    end
  end

  // receive side: shift in at the LSB, accumulate CRC inside the window
  always_ff @(posedge clk) begin
    if (!rstN || stb.rxClear) begin
      rxWordQ <= '0;
      rxCrcQ  <= '0;
      crcErrQ <= 1'b0;
    end else begin
      if (stb.rxShift) begin
        rxWordQ <= {rxWordQ[LONG_BITS-2:0], cmdIn};
        if (stb.rxCrcEn) rxCrcQ <= crc7Step(rxCrcQ, cmdIn);
      end
      if (stb.rxCheck) crcErrQ <= stb.checkCrc && (rxCrcQ != rxWordQ[CRC_W:1]);
    end
  end

  // R3: the wire value moves only on a transmit step from a falling edge
  a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdOut) |-> $past(txShiftEv));

endmodule

// File: rtl/sd_cmd_xcvr.sv
module sd_cmd_xcvr
  import sdcmd_pkg::*;
#(
  parameter int CLK_HALF     = 2,
  parameter int IDLE_CLKS    = 12,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdStart,
  input  logic [5:0]   cmdIndex,
  input  logic [31:0]  cmdArg,
  input  logic [1:0]   respKind,
  output logic         busy,
  output logic         done,
  output logic         respTimeout,
  output logic         respCrcErr,
  output logic [135:0] respWord,
  output logic         cardClk,
  output logic         cmdOut,
  output logic         cmdOe,
  input  logic         cmdIn
);
  dpStrobe_t stb;
  logic      clkEn, riseEv, fallEv;

  sdcmd_clkgen #(.CLK_HALF(CLK_HALF)) uClk (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .cardClk(cardClk), .riseEv(riseEv), .fallEv(fallEv)
  );

  sdcmd_ctrl #(.IDLE_CLKS(IDLE_CLKS), .RESP_TIMEOUT(RESP_TIMEOUT)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .respKind(respKind),
    .cmdIn(cmdIn), .riseEv(riseEv), .fallEv(fallEv), .stb(stb),
    .clkEn(clkEn), .cmdOe(cmdOe), .busy(busy), .done(done),
    .respTimeout(respTimeout)
  );

  sdcmd_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .cmdIn(cmdIn), .cmdOut(cmdOut), .respWord(respWord), .respCrcErr(respCrcErr)
  );

  // R7: a timed-out transaction never reports a CRC error
  a_r7_timeout_no_crcerr: assert property (@(posedge clk) disable iff (!rstN)
    (done && respTimeout) |-> !respCrcErr);

endmodule

// File: tb/tb_sd_cmd_xcvr.sv
module tb_sd_cmd_xcvr;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdStart = 1'b0;
  logic [5:0]   cmdIndex = '0;
  logic [31:0]  cmdArg = '0;
  logic [1:0]   respKind = '0;
  logic         busy, done, respTimeout, respCrcErr, cardClk, cmdOut, cmdOe;
  logic [135:0] respWord;
  logic         cmdIn;
  logic         cardDrv = 1'b0;
  logic         cardBit = 1'b1;

  int nTests = 0;
  int nFail  = 0;
  int r3Bad  = 0;
  int clash  = 0;

  always #10 clk = ~clk;

  assign cmdIn = cmdOe ? cmdOut : (cardDrv ? cardBit : 1'b1);

  sd_cmd_xcvr dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .respKind(respKind), .busy(busy), .done(done),
    .respTimeout(respTimeout), .respCrcErr(respCrcErr), .respWord(respWord),
    .cardClk(cardClk), .cmdOut(cmdOut), .cmdOe(cmdOe), .cmdIn(cmdIn)
  );

  task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // polynomial long division of msg*x^7 by x^7 + x^3 + 1
  function automatic logic [6:0] refCrc7(input logic [127:0] msg, input int nBits);
    logic [7:0] rem;
    rem = '0;
    for (int i = nBits - 1; i >= 0; i--) begin
      rem = {rem[6:0], msg[i]};
      if (rem[7]) rem = rem ^ 8'h89;
    end
    for (int i = 0; i < 7; i++) begin
      rem = {rem[6:0], 1'b0};
      if (rem[7]) rem = rem ^ 8'h89;
    end
    return rem[6:0];
  endfunction

  function automatic logic [47:0] cmdToken(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] m;
    m = {2'b01, idx, arg};
    return {m, refCrc7({88'b0, m}, 40), 1'b1};
  endfunction

  // R3: wire changes only together with a card-clock fall
  logic prevOut = 1'b1, prevCk = 1'b0;
  always @(negedge clk) begin
    if (rstN && cmdOut !== prevOut && !(prevCk == 1'b1 && cardClk == 1'b0)) r3Bad++;
    if (cmdOe && cardDrv) clash++;
    prevOut = cmdOut;
    prevCk  = cardClk;
  end

  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                        input int lat, input bit corrupt, input bit poke);
    logic [135:0] resp, expWord;
    logic [119:0] payload;
    logic [39:0]  m;
    logic [47:0]  got;
    int           respLen, pre, nBits, waitC;
    bit           expTo, expErr;

    got = '0;
    if (kind == 2'd3) begin
      payload = {$urandom, $urandom, $urandom, $urandom};
      resp    = {2'b00, 6'h3F, payload, refCrc7({8'b0, payload}, 120), 1'b1};
      respLen = 136;
    end else begin
      m       = {2'b00, idx, arg};
      resp    = {88'b0, m, (kind == 2'd2) ? 7'h7F : refCrc7({88'b0, m}, 40), 1'b1};
      respLen = 48;
    end
    if (corrupt) resp[3] = ~resp[3];
    expTo   = (kind != 2'd0) && (lat > 64);
    expWord = (kind == 2'd0 || expTo) ? '0 : resp;
    expErr  = corrupt && !expTo && (kind == 2'd1 || kind == 2'd3);

    @(negedge clk);
    cmdIndex = idx; cmdArg = arg; respKind = kind; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    fork
      begin
        waitC = 0;
        if (poke) begin
          repeat (20) @(negedge clk);
          cmdIndex = ~idx; cmdArg = ~arg; respKind = 2'd0; cmdStart = 1'b1;
          @(negedge clk);
          cmdStart = 1'b0;
        end
        while (!done && waitC < 20000) begin
          @(negedge clk);
          waitC++;
        end
      end
      begin
        pre = 0; nBits = 0;
        while (nBits < 48) begin
          @(posedge cardClk);
          if (cmdOe) begin
            got = {got[46:0], cmdOut};
            nBits++;
          end else pre++;
        end
        if (kind != 2'd0 && lat <= 64) begin
          repeat (lat) @(negedge cardClk);
          for (int i = respLen - 1; i >= 0; i--) begin
            cardBit = resp[i];
            cardDrv = 1'b1;
            @(negedge cardClk);
          end
          cardDrv = 1'b0;
          cardBit = 1'b1;
        end
      end
    join
    chk(got == cmdToken(idx, arg), poke ? "R12 token unchanged by late start" : "R1 token format",
        {88'b0, got}, {88'b0, cmdToken(idx, arg)});
    chk(pre == 12, "R4 idle clocks before token", pre, 12);
    if (idx == 6'd0 && arg == 32'd0) chk(got[7:0] == 8'h95, "R2 CRC7 of reset command", got[7:0], 8'h95);
    chk(done === 1'b1 && busy === 1'b0 && cardClk === 1'b0, "R13 done with busy low and clock parked",
        {done, busy, cardClk}, 3'b100);
    chk(respWord === expWord, "R8 reply word", respWord, expWord);
    chk(respTimeout === expTo, expTo ? "R7 timeout flag" : "R6 R5 no timeout", respTimeout, expTo);
    chk(respCrcErr === expErr,
        (kind == 2'd3) ? "R10 long CRC" : (kind == 2'd2) ? "R11 CRC skipped" : "R9 short CRC",
        respCrcErr, expErr);
    if (poke) begin
      waitC = 0;
      repeat (100) begin
        @(negedge clk);
        if (done || busy) waitC++;
      end
      chk(waitC == 0, "R12 single completion", waitC, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cardClk && !cmdOe && cmdOut, "R13 reset state",
        {busy, done, cardClk, cmdOe, cmdOut}, 5'b00001);

    runCmd(6'd0, 32'd0, 2'd0, 0, 1'b0, 1'b0);              // R2, R5 no reply
    runCmd(6'd8, 32'h000001AA, 2'd1, 1, 1'b0, 1'b0);       // R6 earliest start bit
    runCmd(6'd17, 32'h12345678, 2'd1, 64, 1'b0, 1'b0);     // R6 last edge of window
    runCmd(6'd17, 32'h12345678, 2'd1, 65, 1'b0, 1'b0);     // R7 one edge too late
    runCmd(6'd41, 32'h40FF8000, 2'd2, 5, 1'b1, 1'b0);      // R11 bad CRC ignored
    runCmd(6'd2, 32'h0, 2'd3, 3, 1'b0, 1'b0);              // R10 good long
    runCmd(6'd9, 32'hABCD0000, 2'd3, 10, 1'b1, 1'b0);      // R10 bad long
    runCmd(6'd13, 32'hABCD0000, 2'd1, 7, 1'b1, 1'b0);      // R9 bad short
    runCmd(6'd55, 32'hDEADBEEF, 2'd1, 4, 1'b0, 1'b1);      // R12 start while busy

    for (int n = 0; n < 20; n++) begin
      runCmd(6'($urandom), $urandom, 2'(1 + $urandom % 3), 1 + int'($urandom % 64),
             1'($urandom), 1'b0);
    end

    chk(r3Bad == 0, "R3 wire changes only on falling edge", r3Bad, 0);
    chk(clash == 0, "R4 no drive overlap with card", clash, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule